// File: doc/BRIEF.md
# Processor Wait and Debug State Controller

This block follows the processing state of a processor core. The states are reset, normal execution, low-power wait and halted debug. It takes decoded instruction strobes, debug sources, interrupt information and a debugger exit command. From these it drives a pipeline stall, an enable for the core's global clock, the current state code and a one-cycle request for debug-exception servicing.

A WAIT instruction moves the core into wait. The global clock enable is removed only after a parameterised delay. Wake-up causes are arbitrated by a fixed priority. A maskable interrupt wakes the core only if its level is strictly above the core's 3-bit mask. A debug request taken in wait goes either to the halted state or, depending on a configuration input, back to execution with an exception request. Debug is left only through a single-cycle exit command.

The controller runs on an ungated clock. The pipeline, interrupt controller, test access port and clock tree are outside it.

Top module: `wait_debug_ctrl`

## Requirements
- R1: While `rst_n` is low, the controller shows the following at once, without waiting for a clock edge: `state_o` is 2'b00, `clk_en_o` is 1, `stall_o` is 1 and `dbg_exc_o` is 0.
- R2: The first clock edge after `rst_n` rises moves the state to debug (2'b11) if `jtag_req_i` or `dbg_pin_i` is high at that edge. The pin counts whatever the value of `pin_is_req_i`. Otherwise the state moves to normal (2'b01).
- R3: The state codes are 2'b00 reset, 2'b01 normal, 2'b10 wait and 2'b11 debug. `stall_o` is high in every state except normal.
- R4: In normal, `jtag_req_i`, or `dbg_pin_i` while `pin_is_req_i` is 1, moves the state to debug at the next edge. With `pin_is_req_i` at 0, the pin has no effect.
- R5: In normal, `op_debugev_i` with `emu_evt_en_i` high enters debug. `op_debug_i` enters debug only when `emu_evt_en_i` is high and `dbg_disable_i` is low. In every other combination these strobes leave the state unchanged.
- R6: In normal, `op_wait_i` enters wait at the next edge, unless a debug entry of R4 or R5 is present in the same cycle.
- R7: `clk_en_o` falls at the DELAY-th edge after the edge that entered wait (default DELAY=4). It stays low until wait is left, and it is high in every other state.
- R8: A wake cause present at any edge before the clock is gated leaves wait, and `clk_en_o` never goes low in that case.
- R9: In wait, `irq_valid_i` wakes the core to normal only when `irq_level_i` is greater than `core_mask_i`. A level equal to or below the mask is ignored.
- R10: In wait, `nmi_i` wakes the core to normal.
- R11: In wait, a debug request (`jtag_req_i`, or `dbg_pin_i` with `pin_is_req_i`=1) goes to debug when `dbg_to_exc_i` is 0. When `dbg_to_exc_i` is 1 it goes to normal, and `dbg_exc_o` is high for exactly that one cycle.
- R12: When several wake causes are present together, a debug request takes priority over NMI, and NMI over a maskable interrupt.
- R13: In debug, the state stays 2'b11 until `dbg_exit_i` is high at an edge, and then returns to normal. All other inputs are ignored meanwhile.
- R14: Pulling `rst_n` low during wait, including after gating, gives the reset state and `clk_en_o`=1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ungated controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| jtag_req_i | input | 1 | Debug request from the test access port |
| dbg_pin_i | input | 1 | External debug pin |
| pin_is_req_i | input | 1 | 1: the pin acts as a debug request at any time |
| emu_evt_en_i | input | 1 | Emulation logic set to produce a debug event |
| op_wait_i | input | 1 | Decoded WAIT instruction strobe |
| op_debug_i | input | 1 | Decoded DEBUG instruction strobe |
| op_debugev_i | input | 1 | Decoded DEBUGEV instruction strobe |
| dbg_disable_i | input | 1 | Disables debug entry from the DEBUG instruction |
| irq_valid_i | input | 1 | A maskable interrupt is pending |
| irq_level_i | input | LVL_W | Priority level of the pending interrupt |
| core_mask_i | input | LVL_W | Current core priority mask |
| nmi_i | input | 1 | Non-maskable interrupt request |
| dbg_exit_i | input | 1 | Exit command pulse from the debugger |
| dbg_to_exc_i | input | 1 | 1: debug wake from wait is serviced as an exception |
| stall_o | output | 1 | Pipeline stall |
| clk_en_o | output | 1 | Global clock enable |
| state_o | output | 2 | Current state code |
| dbg_exc_o | output | 1 | Debug-exception servicing request |

## Verification
The checker tests a set of rules on every cycle:
- debug persists without an exit command, and an exit command returns the core to normal;
- a request from the test port in normal always reaches debug;
- NMI wakes from wait when no debug source is active;
- the clock enable is low only in wait and only falls after a run of wait cycles;
- the exception flag never lasts two cycles.

The bench scenarios are needed for the exact gating delay and for a wake that cancels gating. They also cover the strict level-against-mask comparison, the ordering among simultaneous wake causes, entry to debug straight out of reset, and the immediate effect of an asynchronous reset during gated wait.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'b00,
        ST_RUN   = 2'b01,
        ST_WAIT  = 2'b10,
        ST_HALT  = 2'b11
    } core_st_e;

    typedef enum logic [1:0] {
        WK_NONE  = 2'b00,
        WK_DEBUG = 2'b01,
        WK_NMI   = 2'b10,
        WK_IRQ   = 2'b11
    } wake_e;

    typedef struct packed {
        core_st_e st;
        logic     exc;
    } fsm_s;

endpackage

// File: rtl/wdc_dbg_src.sv
// Decodes debug entry sources: external requests and instruction-driven events.
module wdc_dbg_src (
    input  logic jtag_req_i,
    input  logic dbg_pin_i,
    input  logic pin_is_req_i,
    input  logic emu_evt_en_i,
    input  logic op_debug_i,
    input  logic op_debugev_i,
    input  logic dbg_disable_i,
    output logic ext_req_o,
    output logic instr_req_o
);
    always_comb begin
        ext_req_o   = jtag_req_i | (dbg_pin_i & pin_is_req_i);
        instr_req_o = emu_evt_en_i & (op_debugev_i | (op_debug_i & ~dbg_disable_i));
    end
endmodule

// File: rtl/wdc_wake_arb.sv
// Fixed-priority wake arbiter for the wait state: debug > NMI > maskable IRQ.
module wdc_wake_arb
    import wdc_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             dbg_req_i,
    input  logic             nmi_i,
    input  logic             irq_valid_i,
    input  logic [LVL_W-1:0] irq_level_i,
    input  logic [LVL_W-1:0] core_mask_i,
    output wake_e            wake_o
);
    logic irq_wins;

    always_comb begin
        irq_wins = irq_valid_i && (irq_level_i > core_mask_i);
        if (dbg_req_i)     wake_o = WK_DEBUG;
        else if (nmi_i)    wake_o = WK_NMI;
        else if (irq_wins) wake_o = WK_IRQ;
        else               wake_o = WK_NONE;
    end
endmodule

// File: rtl/wdc_gate_timer.sv
// Counts wait cycles and turns the global clock off after DELAY of them.
module wdc_gate_timer #(
    parameter int DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic clk_off_o
);
    localparam int CNT_W = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             off;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!hold_i) begin
            tmr_d.cnt = '0;
            tmr_d.off = 1'b0;
        end else if (!tmr_q.off) begin
            if (tmr_q.cnt == LAST) tmr_d.off = 1'b1;
            else                   tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign clk_off_o = tmr_q.off;
endmodule

// File: rtl/wait_debug_ctrl.sv
// Processing-state controller: reset, normal, low-power wait and halted debug.
module wait_debug_ctrl
    import wdc_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int DELAY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             jtag_req_i,
    input  logic             dbg_pin_i,
    input  logic             pin_is_req_i,
    input  logic             emu_evt_en_i,
    input  logic             op_wait_i,
    input  logic             op_debug_i,
    input  logic             op_debugev_i,
    input  logic             dbg_disable_i,
    input  logic             irq_valid_i,
    input  logic [LVL_W-1:0] irq_level_i,
    input  logic [LVL_W-1:0] core_mask_i,
    input  logic             nmi_i,
    input  logic             dbg_exit_i,
    input  logic             dbg_to_exc_i,
    output logic             stall_o,
    output logic             clk_en_o,
    output logic [1:0]       state_o,
    output logic             dbg_exc_o
);
    logic  ext_req, instr_req, wait_hold, clk_off;
    wake_e wake;
    fsm_s  fsm_d, fsm_q;

    wdc_dbg_src u_src (
        .jtag_req_i    (jtag_req_i),
        .dbg_pin_i     (dbg_pin_i),
        .pin_is_req_i  (pin_is_req_i),
        .emu_evt_en_i  (emu_evt_en_i),
        .op_debug_i    (op_debug_i),
        .op_debugev_i  (op_debugev_i),
        .dbg_disable_i (dbg_disable_i),
        .ext_req_o     (ext_req),
        .instr_req_o   (instr_req)
    );

    wdc_wake_arb #(.LVL_W(LVL_W)) u_arb (
        .dbg_req_i   (ext_req),
        .nmi_i       (nmi_i),
        .irq_valid_i (irq_valid_i),
        .irq_level_i (irq_level_i),
        .core_mask_i (core_mask_i),
        .wake_o      (wake)
    );

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.exc = 1'b0;
        unique case (fsm_q.st)
            ST_RESET: begin
                // A request still held at reset release skips instruction execution.
                fsm_d.st = (jtag_req_i || dbg_pin_i) ? ST_HALT : ST_RUN;
            end
            ST_RUN: begin
                if (ext_req || instr_req) fsm_d.st = ST_HALT;
                else if (op_wait_i)       fsm_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                unique case (wake)
                    WK_DEBUG: begin
                        if (dbg_to_exc_i) begin
                            fsm_d.st  = ST_RUN;
                            fsm_d.exc = 1'b1;
                        end else begin
                            fsm_d.st = ST_HALT;
                        end
                    end
                    WK_NMI, WK_IRQ: fsm_d.st = ST_RUN;
                    default:        fsm_d.st = ST_WAIT;
                endcase
            end
            ST_HALT: begin
                if (dbg_exit_i) fsm_d.st = ST_RUN;
            end
            default: fsm_d.st = ST_RESET;
        endcase
        wait_hold = (fsm_q.st == ST_WAIT) && (fsm_d.st == ST_WAIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_RESET, exc: 1'b0};
        else        fsm_q <= fsm_d;
    end

    wdc_gate_timer #(.DELAY(DELAY)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (wait_hold),
        .clk_off_o (clk_off)
    );

    assign state_o   = fsm_q.st;
    assign stall_o   = (fsm_q.st != ST_RUN);
    assign clk_en_o  = ~clk_off;
    assign dbg_exc_o = fsm_q.exc;
endmodule

// File: rtl/wdc_checker.sv
module wdc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       jtag_req_i,
    input logic       dbg_pin_i,
    input logic       pin_is_req_i,
    input logic       nmi_i,
    input logic       dbg_exit_i,
    input logic       clk_en_o,
    input logic [1:0] state_o,
    input logic       dbg_exc_o
);
    // R13: debug persists without an exit command
    a_r13_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b11 && !dbg_exit_i) |=> (state_o == 2'b11));

    // R13: exit command returns to normal
    a_r13_exit_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b11 && dbg_exit_i) |=> (state_o == 2'b01));

    // R4: test-port request in normal reaches debug
    a_r4_jtag_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b01 && jtag_req_i) |=> (state_o == 2'b11));

    // R10: NMI wakes from wait when no debug source is active
    a_r10_nmi_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10 && nmi_i && !jtag_req_i && !(dbg_pin_i && pin_is_req_i))
        |=> (state_o == 2'b01));

    // R7: clock is off only inside wait
    a_r7_off_only_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en_o |-> (state_o == 2'b10));

    // R7: the enable falls only after a wait cycle has already passed
    a_r7_fall_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en_o) |-> ($past(state_o) == 2'b10));

    // R11: exception request lasts one cycle
    a_r11_exc_single: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_exc_o |=> !dbg_exc_o);
endmodule

bind wait_debug_ctrl wdc_checker u_wdc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .jtag_req_i   (jtag_req_i),
    .dbg_pin_i    (dbg_pin_i),
    .pin_is_req_i (pin_is_req_i),
    .nmi_i        (nmi_i),
    .dbg_exit_i   (dbg_exit_i),
    .clk_en_o     (clk_en_o),
    .state_o      (state_o),
    .dbg_exc_o    (dbg_exc_o)
);

// File: tb/wait_debug_ctrl_tb_top.sv
`timescale 1ns/100ps
module wait_debug_ctrl_tb_top;
    localparam int LVL_W = 3;
    localparam int DELAY = 4;
    localparam logic [1:0] S_RST = 2'b00, S_RUN = 2'b01, S_WAIT = 2'b10, S_HALT = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic jtag_req = 0, dbg_pin = 0, pin_is_req = 0, emu_evt_en = 0;
    logic op_wait = 0, op_debug = 0, op_debugev = 0, dbg_disable = 0;
    logic irq_valid = 0, nmi = 0, dbg_exit = 0, dbg_to_exc = 0;
    logic [LVL_W-1:0] irq_level = '0, core_mask = '0;
    logic stall, clk_en, dbg_exc;
    logic [1:0] state;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wait_debug_ctrl #(.LVL_W(LVL_W), .DELAY(DELAY)) dut_i (
        .clk(clk), .rst_n(rst_n), .jtag_req_i(jtag_req), .dbg_pin_i(dbg_pin),
        .pin_is_req_i(pin_is_req), .emu_evt_en_i(emu_evt_en), .op_wait_i(op_wait),
        .op_debug_i(op_debug), .op_debugev_i(op_debugev), .dbg_disable_i(dbg_disable),
        .irq_valid_i(irq_valid), .irq_level_i(irq_level), .core_mask_i(core_mask),
        .nmi_i(nmi), .dbg_exit_i(dbg_exit), .dbg_to_exc_i(dbg_to_exc),
        .stall_o(stall), .clk_en_o(clk_en), .state_o(state), .dbg_exc_o(dbg_exc)
    );

    typedef struct {
        logic [1:0] st;
        logic       en;
        logic       exc;
        string      tag;
    } exp_t;

    exp_t sb[$];

    task automatic compare(input exp_t e);
        logic exp_stall;
        exp_stall = (e.st != S_RUN);
        n_checks++;
        if (state !== e.st || clk_en !== e.en || dbg_exc !== e.exc || stall !== exp_stall) begin
            n_fail++;
            $display("FAIL %s: got st=%b en=%b exc=%b stall=%b, expected st=%b en=%b exc=%b stall=%b",
                     e.tag, state, clk_en, dbg_exc, stall, e.st, e.en, e.exc, exp_stall);
        end
    endtask

    // Monitor: pops one expected item per clock, after the edge settles.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    // Driver: inputs are already set at the negedge; expectation is for after the next edge.
    task automatic step(input logic [1:0] st, input logic en, input logic exc, input string tag);
        exp_t e;
        e.st = st; e.en = en; e.exc = exc; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic now(input logic [1:0] st, input logic en, input logic exc, input string tag);
        exp_t e;
        e.st = st; e.en = en; e.exc = exc; e.tag = tag;
        compare(e);
    endtask

    task automatic enter_wait();
        op_wait = 1;
        step(S_WAIT, 1, 0, "R6 wait entry");
        op_wait = 0;
    endtask

    task automatic leave_halt();
        dbg_exit = 1;
        step(S_RUN, 1, 0, "R13 exit command");
        dbg_exit = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        now(S_RST, 1, 0, "R1 reset state");
        rst_n = 1;
        step(S_RUN, 1, 0, "R2 release to normal");

        // R7 gating after DELAY edges, R9 equal/higher level
        enter_wait();
        for (int i = 1; i < DELAY; i++) step(S_WAIT, 1, 0, "R7 clock kept during delay");
        step(S_WAIT, 0, 0, "R7 clock gated");
        irq_valid = 1; irq_level = 3'd3; core_mask = 3'd3;
        step(S_WAIT, 0, 0, "R9 level equal to mask ignored");
        irq_level = 3'd4;
        step(S_RUN, 1, 0, "R9 higher level wakes");
        irq_valid = 0;

        // R8 / R10: NMI during delay cancels gating
        enter_wait();
        step(S_WAIT, 1, 0, "R8 still in delay");
        nmi = 1;
        step(S_RUN, 1, 0, "R10 nmi wakes");
        nmi = 0;
        for (int i = 0; i < DELAY + 1; i++) step(S_RUN, 1, 0, "R8 clock never gated");

        // R11 debug wake to halt, R13 holding
        enter_wait();
        irq_valid = 1; irq_level = 3'd7; core_mask = 3'd7;
        for (int i = 1; i < DELAY; i++) step(S_WAIT, 1, 0, "R7 delay");
        step(S_WAIT, 0, 0, "R9 level 7 vs mask 7 ignored");
        irq_valid = 0;
        jtag_req = 1;
        step(S_HALT, 1, 0, "R11 debug wake to halt");
        jtag_req = 0; nmi = 1; op_wait = 1;
        step(S_HALT, 1, 0, "R13 other inputs ignored");
        nmi = 0; op_wait = 0;
        step(S_HALT, 1, 0, "R13 held");
        leave_halt();

        // R11 pin in wait: mode 0 ignored, mode 1 with exception servicing
        enter_wait();
        dbg_pin = 1;
        step(S_WAIT, 1, 0, "R11 pin ignored without request mode");
        pin_is_req = 1; dbg_to_exc = 1;
        step(S_RUN, 1, 1, "R11 exception servicing");
        dbg_pin = 0; pin_is_req = 0; dbg_to_exc = 0;
        step(S_RUN, 1, 0, "R11 exception flag one cycle");

        // R12 priority: debug over NMI and IRQ
        enter_wait();
        jtag_req = 1; nmi = 1; irq_valid = 1; irq_level = 3'd5; core_mask = 3'd0;
        step(S_HALT, 1, 0, "R12 debug beats nmi");
        jtag_req = 0;
        leave_halt();
        irq_valid = 0; nmi = 0;
        enter_wait();
        nmi = 1; irq_valid = 1; dbg_to_exc = 1;
        step(S_RUN, 1, 0, "R12 nmi beats irq without exception");
        nmi = 0; irq_valid = 0; dbg_to_exc = 0;

        // R5 instruction entries
        op_debug = 1; dbg_disable = 1; emu_evt_en = 1;
        step(S_RUN, 1, 0, "R5 debug disabled");
        dbg_disable = 0; emu_evt_en = 0;
        step(S_RUN, 1, 0, "R5 no emulation event");
        emu_evt_en = 1;
        step(S_HALT, 1, 0, "R5 debug instruction enters");
        op_debug = 0;
        leave_halt();
        op_debugev = 1; dbg_disable = 1;
        step(S_HALT, 1, 0, "R5 debugev ignores disable");
        op_debugev = 0; dbg_disable = 0;
        leave_halt();
        op_debugev = 1; emu_evt_en = 0;
        step(S_RUN, 1, 0, "R5 debugev without event");
        op_debugev = 0;

        // R4 external requests in normal
        jtag_req = 1;
        step(S_HALT, 1, 0, "R4 jtag in normal");
        jtag_req = 0;
        leave_halt();
        dbg_pin = 1;
        step(S_RUN, 1, 0, "R4 pin ignored in mode 0");
        pin_is_req = 1;
        step(S_HALT, 1, 0, "R4 pin in request mode");
        dbg_pin = 0; pin_is_req = 0;
        leave_halt();

        // R14 reset while gated, then R2 release into debug
        enter_wait();
        for (int i = 1; i < DELAY; i++) step(S_WAIT, 1, 0, "R7 delay");
        step(S_WAIT, 0, 0, "R7 gated before reset");
        rst_n = 0; jtag_req = 1;
        #1;
        now(S_RST, 1, 0, "R14 async reset re-enables clock");
        @(negedge clk);
        rst_n = 1;
        step(S_HALT, 1, 0, "R2 jtag held through reset");
        jtag_req = 0;
        leave_halt();
        rst_n = 0; dbg_pin = 1;
        #1;
        now(S_RST, 1, 0, "R1 reset from normal");
        @(negedge clk);
        rst_n = 1;
        step(S_HALT, 1, 0, "R2 pin held through reset in mode 0");
        dbg_pin = 0;
        leave_halt();
        rst_n = 0;
        #1;
        now(S_RST, 1, 0, "R3 reset code");
        @(negedge clk);
        rst_n = 1;
        step(S_RUN, 1, 0, "R2 plain release");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule